// File: doc/BRIEF.md
# Keyed-Service Core Watchdog

This block watches for a stalled processor. Once enabled, a bus-clock counter runs toward a power-of-two limit chosen by a 3-bit period select. Software keeps it from expiring by writing two key bytes to a byte-wide service register: first 0x55, then later 0xAA. Any other bus traffic may come between the two keys. If the limit is reached first, an interrupt flag is set and the interrupt request output goes high. The key pair cannot cancel that request. Only a write-one-to-clear to the flag removes it.

When escalation is enabled and the interrupt stays uncleared for one more full period, the block pulses a transfer-acknowledge strobe for one cycle. This lets a hung bus cycle end so that the interrupt can be taken. A sticky flag records that the strobe was issued.

The register interface uses address 0 for control and status and address 1 for the service byte. A test preload port can jump the counter to any value, so that very long periods can be checked in a few cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: The control register bits [5:3] select the timeout. A value of s gives 2^e bus clocks after the count restarts, with e = 9, 11, 13, 15, 19, 23, 27, 31 for s = 0 to 7. The interrupt flag then sets and `irq` goes high.
- R2: After reset, the control register reads 0x00: enable (bit 7) is 0, select is 000, escalation enable (bit 2) is 0, and both flags are 0. `irq` and `xfer_ack` are low, and the timer does not run.
- R3: A write of 0x55 to address 1 followed later by a write of 0xAA to address 1 restarts the count, as long as no timeout has occurred. Any reads, control writes or other service writes may come between the two keys.
- R4: A write of 0xAA with no pending 0x55 does not restart the count. A service write of any other byte leaves the pending-key state unchanged.
- R5: Once the interrupt flag is set, writing the key pair does not clear the flag or `irq`. It also does not delay escalation.
- R6: Writing 1 to control bit 0 clears the interrupt flag and restarts the count. Writing 0 to bit 0 leaves the flag set.
- R7: With escalation enabled (bit 2), if the interrupt flag remains set for one further full period, `xfer_ack` is high for exactly one cycle. With escalation disabled, `xfer_ack` never rises.
- R8: The escalation flag (bit 1) sets when `xfer_ack` is issued. It is cleared by writing 1 to bit 1.
- R9: Clearing the enable stops the counter, returns it to zero and drops any pending 0x55 key.
- R10: Writing a different period select restarts the count from zero under the new period.
- R11: Reading address 1 returns the last byte written there.
- R12: A pulse on `tst_load` loads `tst_value` into the counter. The timeout then follows after (period - value) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects control/status, 1 selects the service byte |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for the addressed register |
| tst_load | input | 1 | Test hook: load the counter |
| tst_value | input | CNT_W | Test hook: value to load |
| irq | output | 1 | Interrupt request, equal to the interrupt flag |
| xfer_ack | output | 1 | One-cycle forced transfer-acknowledge strobe |

## Verification
The bench builds the block with its defaults: a 32-bit counter and an 8-bit data path. With these values, selects 0 and 1 (512 and 2048 clocks) run natively. Key ordering, disable, period change and two-period escalation are all checked against exact cycle numbers. The 2^19 and 2^31 selects, which would otherwise take far too long, become reachable through the preload port: the counter is loaded a few tens of cycles short of the limit.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int TSEL_W = 3;

  // exponent of the timeout period for each select code
  function automatic logic [5:0] sel_exp(input logic [TSEL_W-1:0] s);
    logic [5:0] e;
    case (s)
      3'd0: e = 6'd9;
      3'd1: e = 6'd11;
      3'd2: e = 6'd13;
      3'd3: e = 6'd15;
      3'd4: e = 6'd19;
      3'd5: e = 6'd23;
      3'd6: e = 6'd27;
      default: e = 6'd31;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/kwd_timebase.sv
module kwd_timebase
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                restart,
  input  logic                load,
  input  logic [CNT_W-1:0]    load_val,
  input  logic [TSEL_W-1:0]   tsel,
  output logic                terminal
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last     = (ONE << sel_exp(tsel)) - ONE;
  assign terminal = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (run)        cnt <= terminal ? '0 : cnt + ONE;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> (cnt == '0) || $past(load)) else $error("counter moved while stopped"); // R9
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq #(
  parameter int             DW       = 8,
  parameter logic [DW-1:0]  KEY_ARM  = 8'h55,
  parameter logic [DW-1:0]  KEY_FIRE = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          armed,
  output logic          fire,
  output logic [DW-1:0] shadow
);
  logic is_arm, is_fire;

  assign is_arm  = wr && (wdata == KEY_ARM);
  assign is_fire = wr && (wdata == KEY_FIRE);
  assign fire    = is_fire && armed && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear)  armed <= 1'b0;
    else if (is_arm)   armed <= 1'b1;
    else if (is_fire)  armed <= 1'b0;
  end

  // service byte has no defined reset value
  always_ff @(posedge clk) begin
    if (wr) shadow <= wdata;
  end

  AST_ARM_ON_KEY: assert property (@(posedge clk) disable iff (rst)
    (is_arm && !clear) |=> armed) else $error("first key not held"); // R3
  AST_DISARM_OFF: assert property (@(posedge clk) disable iff (rst)
    clear |=> !armed) else $error("pending key kept while disabled"); // R9
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(is_arm) || $past(armed)) else $error("service without first key"); // R4
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int            CNT_W    = 32,
  parameter int            DW       = 8,
  parameter logic [DW-1:0] KEY_ARM  = 8'h55,
  parameter logic [DW-1:0] KEY_FIRE = 8'hAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic             tst_load,
  input  logic [CNT_W-1:0] tst_value,
  output logic             irq,
  output logic             xfer_ack
);
  localparam int B_EN   = 7;
  localparam int B_TSEL = 3;
  localparam int B_ESCE = 2;
  localparam int B_ESCF = 1;
  localparam int B_IRQF = 0;

  logic              en_q, esc_en_q, irq_q, esc_q, ack_q;
  logic [TSEL_W-1:0] tsel_q, tsel_new;
  logic              ctrl_wr, svc_wr, irq_w1c, esc_w1c, tsel_chg;
  logic              fire, armed, terminal, restart, escalate;
  logic [DW-1:0]     shadow, ctrl_rd;

  assign ctrl_wr  = wr_en && !addr;
  assign svc_wr   = wr_en && addr;
  assign tsel_new = wr_data[B_TSEL +: TSEL_W];
  assign irq_w1c  = ctrl_wr && wr_data[B_IRQF];
  assign esc_w1c  = ctrl_wr && wr_data[B_ESCF];
  assign tsel_chg = ctrl_wr && (tsel_new != tsel_q);
  assign escalate = terminal && irq_q && esc_en_q;
  assign restart  = !en_q || (fire && !irq_q) || tsel_chg || (irq_w1c && irq_q);

  kwd_keyseq #(.DW(DW), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_keys (
    .clk(clk), .rst(rst), .clear(!en_q), .wr(svc_wr), .wdata(wr_data),
    .armed(armed), .fire(fire), .shadow(shadow)
  );

  kwd_timebase #(.CNT_W(CNT_W)) u_tbase (
    .clk(clk), .rst(rst), .run(en_q), .restart(restart), .load(tst_load),
    .load_val(tst_value), .tsel(tsel_q), .terminal(terminal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      tsel_q   <= '0;
      esc_en_q <= 1'b0;
      irq_q    <= 1'b0;
      esc_q    <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= escalate;
      if (ctrl_wr) begin
        en_q     <= wr_data[B_EN];
        tsel_q   <= tsel_new;
        esc_en_q <= wr_data[B_ESCE];
      end
      if (terminal && !irq_q) irq_q <= 1'b1;
      else if (irq_w1c)       irq_q <= 1'b0;
      if (escalate)           esc_q <= 1'b1;
      else if (esc_w1c)       esc_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[B_EN]                = en_q;
    ctrl_rd[B_TSEL +: TSEL_W]    = tsel_q;
    ctrl_rd[B_ESCE]              = esc_en_q;
    ctrl_rd[B_ESCF]              = esc_q;
    ctrl_rd[B_IRQF]              = irq_q;
  end

  assign rd_data  = addr ? shadow : ctrl_rd;
  assign irq      = irq_q;
  assign xfer_ack = ack_q;

  AST_ACK_AFTER_IRQ: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> $past(irq)) else $error("strobe without pending interrupt"); // R7
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |=> !xfer_ack) else $error("strobe longer than one cycle"); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_w1c) |=> irq) else $error("interrupt dropped without clear"); // R5
  AST_ESC_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> esc_q) else $error("strobe without escalation flag"); // R8
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  localparam int CNT_W = 32;
  localparam int DW    = 8;

  typedef struct {
    string   req;
    int      kind;   // 0 = irq rise, 1 = xfer_ack strobe
    longint  cyc;
  } evt_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             addr = 1'b0;
  logic [DW-1:0]    wr_data = '0;
  logic [DW-1:0]    rd_data;
  logic             tst_load = 1'b0;
  logic [CNT_W-1:0] tst_value = '0;
  logic             irq, xfer_ack;

  int     n_vec = 0;
  int     n_bad = 0;
  longint cyc = 0;
  logic   irq_d = 1'b0;
  evt_t   exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_watchdog #(.CNT_W(CNT_W), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tst_load(tst_load), .tst_value(tst_value),
    .irq(irq), .xfer_ack(xfer_ack)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_evt(input string req, input int kind, input longint at);
    evt_t e;
    e.req = req; e.kind = kind; e.cyc = at;
    exp_q.push_back(e);
  endtask

  // monitor: pops the scoreboard on every observed irq rise or strobe
  task automatic observe(input int kind);
    evt_t e;
    n_vec++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event kind %0d at cycle %0d: actual present expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.cyc != cyc) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 e.req, kind, cyc, e.kind, e.cyc);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (irq && !irq_d) observe(0);
      if (xfer_ack)      observe(1);
    end
    irq_d <= irq;
  end

  task automatic wr(input logic a, input logic [7:0] d, output longint t);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    t = cyc;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #2 v = rd_data;
  endtask

  task automatic preload(input logic [CNT_W-1:0] v, output longint t);
    @(negedge clk);
    tst_load = 1'b1; tst_value = v;
    @(negedge clk);
    tst_load = 1'b0;
    t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    longint t;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R2 reset state
    rd(1'b0, v);       check("R2 ctrl", v, 8'h00);
    check("R2 irq", irq, 0);
    check("R2 ack", xfer_ack, 0);
    idle(600);
    check("R2 not running", irq, 0);

    // R11 readback
    wr(1'b1, 8'h3C, t); rd(1'b1, v); check("R11 readback", v, 8'h3C);

    // R1 select 0
    wr(1'b0, 8'h80, t); expect_evt("R1 period 2^9", 0, t + 512);
    idle(530);

    // R5 keys after timeout, R6 W1C
    wr(1'b1, 8'h55, t); wr(1'b1, 8'hAA, t); idle(3);
    check("R5 irq kept after keys", irq, 1);
    wr(1'b0, 8'h80, t); idle(2);
    check("R6 zero write keeps flag", irq, 1);
    wr(1'b0, 8'h81, t); idle(1);
    check("R6 one clears flag", irq, 0);

    // R3 service with traffic between keys
    idle(300);
    wr(1'b1, 8'h55, t); wr(1'b1, 8'h12, t); rd(1'b0, v);
    wr(1'b1, 8'h55, t); wr(1'b0, 8'h80, t); idle(100);
    wr(1'b1, 8'hAA, t); expect_evt("R3 service restarts", 0, t + 512);
    rd(1'b1, v); check("R11 last key", v, 8'hAA);
    idle(520);

    // R4 unarmed second key does not service
    wr(1'b0, 8'h81, t); expect_evt("R4 no service", 0, t + 512);
    idle(100); wr(1'b1, 8'hAA, t); wr(1'b1, 8'h33, t);
    idle(100); wr(1'b1, 8'hAA, t); idle(330);

    // R9 disable drops pending key and stops counter
    wr(1'b0, 8'h01, t);
    wr(1'b0, 8'h80, t); wr(1'b1, 8'h55, t); idle(50);
    wr(1'b0, 8'h00, t); idle(1000);
    check("R9 stopped", irq, 0);
    wr(1'b0, 8'h80, t); expect_evt("R9 key dropped", 0, t + 512);
    wr(1'b1, 8'hAA, t); idle(530);

    // R10 select change restarts
    wr(1'b0, 8'h01, t); wr(1'b0, 8'h80, t); idle(200);
    wr(1'b0, 8'h88, t); expect_evt("R10 restart at 2^11", 0, t + 2048);
    idle(2060);

    // R12 preload, long periods
    wr(1'b0, 8'h01, t); wr(1'b0, 8'hB8, t);
    preload(32'h8000_0000 - 32'd20, t); expect_evt("R12 2^31", 0, t + 20);
    idle(30);
    wr(1'b0, 8'h01, t); wr(1'b0, 8'hA0, t);
    preload(32'h0008_0000 - 32'd10, t); expect_evt("R12 2^19", 0, t + 10);
    idle(20);

    // R7 escalation, R8 flag
    wr(1'b0, 8'h01, t); wr(1'b0, 8'h84, t);
    expect_evt("R7 timeout", 0, t + 512);
    expect_evt("R7 strobe", 1, t + 1024);
    idle(600);
    wr(1'b1, 8'h55, t); wr(1'b1, 8'hAA, t);
    idle(430);
    rd(1'b0, v); check("R8 flag set", v[1], 1);
    check("R5 irq still set", irq, 1);
    wr(1'b0, 8'h87, t); wr(1'b0, 8'h00, t);
    rd(1'b0, v); check("R8 flags cleared", v, 8'h00);

    // R7 no escalation when disabled
    wr(1'b0, 8'h80, t); expect_evt("R7 timeout no esc", 0, t + 512);
    idle(1100);
    check("R7 irq held", irq, 1);
    wr(1'b0, 8'h01, t); idle(2);

    check("scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule